// File: doc/BRIEF.md
# Packet-Tenure Bus Arbiter with Bootstrap Override

This block decides which of several nodes may drive a shared flit bus. Each node raises its request line when it has a packet ready. The arbiter returns a one-hot grant vector and the binary index of the winner, both from registers. The winning node keeps the bus for as long as it holds the packet-hold line high, so every flit of a packet goes out without interruption and nobody else can take the bus in between.

One node is the bootstrap node. Whenever it requests at a decision point, it beats the rotation. All other nodes share the bus in rotating order, and the search begins at the node after the previous winner. When the holder releases the bus, the next winner is granted on that same clock edge, so back-to-back packets leave no idle cycle on the bus.

For each node, a saturating counter records how many cycles it spent requesting without holding the grant. This gives a measure of contention. The same RTL can also be built as a 4-node plain rotating arbiter with the override switched off.

Top module: `flit_bus_arbiter`

## Requirements
- R1: At most one grant bit is high at any time. While a grant is active, `grant_valid` is 1 and `winner_id` holds the index of the set grant bit. With no grant, `grant_valid` is 0 and `winner_id` is 0.
- R2: Synchronous reset behaves as follows:
  - All grants are cleared and every wait counter is set to zero.
  - The rotation pointer is set to the highest index, so the first rotating search starts at node 0.
- R3: At a decision point, a request from the bootstrap node (index `BOOT_IDX`, default 4) wins regardless of rotation. A decision point is either no grant active, or the holder having `hold` low.
- R4: Without a bootstrap request, the search starts at (last winner + 1) mod N. The first requesting node in ascending wrap-around order wins. The last winner is updated on every grant.
- R5: While the holder keeps `hold` high, the grant does not change, even if other nodes (including the bootstrap node) request.
- R6: When the holder drops `hold`, its grant ends at the next clock edge. If any request is pending at that edge, the new winner's grant appears on the same edge. Otherwise the bus goes idle.
- R7: A holder that does not raise `hold` in its first granted cycle keeps the bus for exactly one cycle.
- R8: A node's wait counter increases by one on each clock edge at which the node requests and does not hold the grant. Otherwise the counter keeps its value. Counter i occupies bits [i*WAIT_W +: WAIT_W] of `wait_cnt`.
- R9: A wait counter at its maximum value (2^WAIT_W - 1) stays there.
- R10: With N=4 and the override disabled, the arbiter is a pure rotating arbiter over 4 nodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | One request line per node |
| hold | input | 1 | Holder keeps the bus while high |
| grant | output | N | One-hot registered grant |
| grant_valid | output | 1 | A grant is active |
| winner_id | output | $clog2(N) | Index of the granted node |
| wait_cnt | output | N*WAIT_W | Packed per-node wait counters |

## Verification
A corrupted rotation pointer appears at the very next decision point: the wrong node is granted, and this shows on `grant` and `winner_id` one edge after the release. A wrong tenure flag (the internal record of whether a grant is active) shows in one of two ways. Either a grant is lost while `hold` is still high, or a release does not bring in the next requester. Both are visible within one cycle. Counter faults build up over time, so the bench reads exact counts after known numbers of waiting cycles and after saturation.

// File: rtl/arb_pkg.sv
package arb_pkg;
  function automatic logic [31:0] onehot32(input int unsigned idx);
    logic [31:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N        = 8,
  parameter int BOOT_EN  = 1,
  parameter int BOOT_IDX = 4,
  localparam int IDW     = $clog2(N)
) (
  input  logic [N-1:0]   req,
  input  logic [IDW-1:0] last,
  output logic           any,
  output logic [IDW-1:0] pick
);
  logic           boot_hit;
  logic           rr_any;
  logic [IDW-1:0] rr_pick;

  generate
    if (BOOT_EN != 0) begin : g_boot
      assign boot_hit = req[BOOT_IDX];
    end else begin : g_noboot
      assign boot_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    rr_any  = 1'b0;
    rr_pick = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!rr_any && req[idx]) begin
        rr_any  = 1'b1;
        rr_pick = IDW'(idx);
      end
    end
  end

  assign any  = rr_any;
  assign pick = boot_hit ? IDW'(BOOT_IDX) : rr_pick;
endmodule

// File: rtl/arb_wait_ctr.sv
module arb_wait_ctr #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [WAIT_W-1:0] cnt
);
  localparam logic [WAIT_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (inc && cnt != MAXV)  cnt <= cnt + 1'b1;
  end

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXV) |=> (cnt == MAXV));
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/arb_wait_bank.sv
module arb_wait_bank #(
  parameter int N      = 8,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      req,
  input  logic [N-1:0]      grant,
  output logic [N*WAIT_W-1:0] cnt_flat
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_ctr
      arb_wait_ctr #(.WAIT_W(WAIT_W)) u_ctr (
        .clk(clk),
        .rst(rst),
        .inc(req[i] & ~grant[i]),
        .cnt(cnt_flat[i*WAIT_W +: WAIT_W])
      );
    end
  endgenerate
endmodule

// File: rtl/flit_bus_arbiter.sv
module flit_bus_arbiter #(
  parameter int N        = 8,
  parameter int BOOT_EN  = 1,
  parameter int BOOT_IDX = 4,
  parameter int WAIT_W   = 8,
  localparam int IDW     = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        req,
  input  logic                hold,
  output logic [N-1:0]        grant,
  output logic                grant_valid,
  output logic [IDW-1:0]      winner_id,
  output logic [N*WAIT_W-1:0] wait_cnt
);
  import arb_pkg::*;

  logic [IDW-1:0] last_q;
  logic           pick_any;
  logic [IDW-1:0] pick_idx;
  logic           decide;

  arb_rr_pick #(.N(N), .BOOT_EN(BOOT_EN), .BOOT_IDX(BOOT_IDX)) u_pick (
    .req (req),
    .last(last_q),
    .any (pick_any),
    .pick(pick_idx)
  );

  assign decide = !grant_valid || !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant       <= '0;
      grant_valid <= 1'b0;
      winner_id   <= '0;
      last_q      <= IDW'(N-1);
    end else if (decide) begin
      if (pick_any) begin
        grant       <= N'(onehot32(int'(pick_idx)));
        grant_valid <= 1'b1;
        winner_id   <= pick_idx;
        last_q      <= pick_idx;
      end else begin
        grant       <= '0;
        grant_valid <= 1'b0;
        winner_id   <= '0;
      end
    end
  end

  arb_wait_bank #(.N(N), .WAIT_W(WAIT_W)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .grant   (grant),
    .cnt_flat(wait_cnt)
  );

  assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (grant_valid == (grant != '0)));
  assert_tenure_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && hold) |=> $stable(grant));
  assert_zero_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !hold && (req != '0)) |=> grant_valid);
  assert_idle_release_R6: assert property (@(posedge clk) disable iff (rst)
    (!hold && (req == '0)) |=> !grant_valid);

  generate
    if (BOOT_EN != 0) begin : g_boot_chk
      assert_boot_wins_R3: assert property (@(posedge clk) disable iff (rst)
        ((!grant_valid || !hold) && req[BOOT_IDX]) |=> grant[BOOT_IDX]);
    end
  endgenerate
endmodule

// File: tb/sim_flit_bus_arbiter.sv
module sim_flit_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0;
  logic       hold = 1'b0;
  logic [7:0] grant;
  logic       gvalid;
  logic [2:0] wid;
  logic [8*WW-1:0] wcnt;

  logic [3:0] req1 = '0;
  logic       hold1 = 1'b0;
  logic [3:0] grant1;
  logic       gvalid1;
  logic [1:0] wid1;
  logic [4*WW-1:0] wcnt1;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flit_bus_arbiter #(.N(8), .BOOT_EN(1), .BOOT_IDX(4), .WAIT_W(WW)) u0 (
    .clk(clk), .rst(rst), .req(req), .hold(hold),
    .grant(grant), .grant_valid(gvalid), .winner_id(wid), .wait_cnt(wcnt));

  flit_bus_arbiter #(.N(4), .BOOT_EN(0), .BOOT_IDX(0), .WAIT_W(WW)) u1 (
    .clk(clk), .rst(rst), .req(req1), .hold(hold1),
    .grant(grant1), .grant_valid(gvalid1), .winner_id(wid1), .wait_cnt(wcnt1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = '0; hold = 1'b0; req1 = '0; hold1 = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] cnt_of(input int i);
    return 32'(wcnt[i*WW +: WW]);
  endfunction

  task automatic t_reset_state();
    do_reset();
    check("R2 grant after reset", 32'(grant), 0);
    check("R1 valid after reset", 32'(gvalid), 0);
    check("R1 winner_id after reset", 32'(wid), 0);
    for (int i = 0; i < 8; i++) check("R2 counter zero", cnt_of(i), 0);
  endtask

  task automatic t_rotate();
    do_reset();
    req = 8'h06; hold = 1'b0;
    step(1); check("R4 first from 0 picks 1", 32'(grant), 32'h02);
    check("R1 winner_id 1", 32'(wid), 1);
    step(1); check("R7 one-cycle tenure then 2", 32'(grant), 32'h04);
    check("R1 winner_id 2", 32'(wid), 2);
    step(1); check("R4 rotate back to 1", 32'(grant), 32'h02);
    do_reset();
    req = 8'h81;
    step(1); check("R4 wrap picks 0", 32'(grant), 32'h01);
    step(1); check("R4 then 7", 32'(grant), 32'h80);
    step(1); check("R4 wrap back to 0", 32'(grant), 32'h01);
  endtask

  task automatic t_boot();
    do_reset();
    req = 8'h13; hold = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(1);
      check("R3 bootstrap wins", 32'(grant), 32'h10);
      check("R3 winner_id 4", 32'(wid), 4);
    end
  endtask

  task automatic t_hold();
    do_reset();
    req = 8'h0A; hold = 1'b1;
    step(1); check("R4 hold test start grant 1", 32'(grant), 32'h02);
    req = 8'h1A;
    step(3); check("R5 no preemption by boot", 32'(grant), 32'h02);
    hold = 1'b0;
    step(1); check("R6 zero-gap handover to 4", 32'(grant), 32'h10);
    check("R6 valid kept", 32'(gvalid), 1);
    req = 8'h0A;
    step(1); check("R4 after 4 search reaches 1", 32'(grant), 32'h02);
    do_reset();
    req = 8'h04; hold = 1'b1;
    step(2); check("R5 sole holder kept", 32'(grant), 32'h04);
    req = 8'h00; hold = 1'b0;
    step(1); check("R6 idle release", 32'(grant), 0);
    check("R6 valid low", 32'(gvalid), 0);
  endtask

  task automatic t_counters();
    do_reset();
    req = 8'h28; hold = 1'b1;
    step(1);
    check("R8 winner 3", 32'(grant), 32'h08);
    check("R8 c3 one wait edge", cnt_of(3), 1);
    check("R8 c5 one", cnt_of(5), 1);
    step(5);
    check("R8 c5 six", cnt_of(5), 6);
    check("R8 c3 unchanged while granted", cnt_of(3), 1);
    check("R8 c0 idle", cnt_of(0), 0);
    req = 8'h00;
    step(1);
    check("R8 c5 stable without request", cnt_of(5), 6);
    do_reset();
    req = 8'h30; hold = 1'b1;
    step(300);
    check("R9 c5 saturated", cnt_of(5), 255);
    check("R9 c4 one", cnt_of(4), 1);
  endtask

  task automatic t_variant();
    do_reset();
    req1 = 4'hF; hold1 = 1'b0;
    step(1); check("R10 v4 first 0", 32'(grant1), 32'h1);
    step(1); check("R10 v4 then 1", 32'(grant1), 32'h2);
    step(1); check("R10 v4 then 2", 32'(grant1), 32'h4);
    step(1); check("R10 v4 then 3", 32'(grant1), 32'h8);
    step(1); check("R10 v4 wrap 0", 32'(grant1), 32'h1);
    check("R10 v4 winner_id", 32'(wid1), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_rotate();
    t_boot();
    t_hold();
    t_counters();
    t_variant();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule